// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block produces the pin activity of one external bus access for a small 8-bit controller core whose machine cycle spans twelve oscillator clocks. The core hands over one request at a time: a 16-bit address, a cycle kind (instruction fetch, data read or data write), the byte to write, and a flag marking an 8-bit indirect data address. The block then runs exactly one twelve-clock machine cycle. It places every strobe edge at a fixed oscillator count within that cycle and returns the fetched or read byte with a one-clock done pulse in the final clock.

The pins are the address latch enable (active high), the active-low program-store enable, read and write strobes, a dedicated high-address byte, and a shared low-address/data byte with a separate output enable. On the shared byte the low address comes first. The port then releases for incoming bytes, or carries the write byte. An instruction fetch leaves the chip only when the external-access input is low and code protection is off. Otherwise the fetch is served internally and the bus stays quiet.

All timing derives from a phase counter clocked by the oscillator. Phases are numbered 0 to 11 within a machine cycle, and an output change for phase p is seen during the clock in which the counter holds p.

Top module: `xbus_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `ale` low, `psen_n`, `rd_n` and `wr_n` high, `ad_oe` low, `rsp_done` low, and `addr_hi` shows `p2_latch`.
- R2: An accepted request runs a twelve-clock machine cycle (phases 0 to 11). On an external cycle `ale` is high in phases 0 and 1 only. `rsp_done` is high for the single clock of phase 11.
- R3: The low address byte `req_addr[7:0]` is driven on `ad_out` with `ad_oe` high in phases 0 to 2, one clock before and one clock after the fall of `ale`.
- R4: A fetch (`req_kind` 00, with 11 treated the same) that goes external holds `psen_n` low in phases 3 to 5 and releases `ad_oe` from phase 3. `ad_in` is captured at the end of phase 5 and shown on `rsp_data` in phase 11.
- R5: A data read (`req_kind` 01) holds `rd_n` low in phases 5 to 10 with `ad_oe` low from phase 3 on. `ad_in` is captured at the end of phase 10 and shown on `rsp_data` in phase 11.
- R6: A data write (`req_kind` 10) holds `wr_n` low in phases 5 to 10. `req_wdata` is driven on `ad_out` with `ad_oe` high in phases 4 to 11.
- R7: `addr_hi` carries `req_addr[15:8]` through an external fetch or a data cycle with `req_short` low. For a data cycle with `req_short` high, and whenever no external cycle runs, it carries `p2_latch`.
- R8: At most one of `psen_n`, `rd_n`, `wr_n` is low at any time, and a data cycle never lowers `psen_n`.
- R9: A request presented while `rsp_done` is high starts the next machine cycle on the following clock, so `ale` rises one clock after `rd_n` or `wr_n` returns high.
- R10: A fetch goes external only when `ext_access_n` is 0 and `code_lock` is 0. With `code_lock` set, `ext_access_n` is ignored. An internal fetch keeps `ale` low, all strobes high and `ad_oe` low, still pulses `rsp_done` in phase 11, and reports `rsp_ext` low. Data cycles report `rsp_ext` high.
- R11: A `req_valid` raised during phases 0 to 10 of a running cycle is ignored. The running cycle's pins are unchanged and the block goes idle after phase 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when idle or in phase 11 |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 fetch |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to write |
| req_short | input | 1 | Data cycle uses an 8-bit indirect address |
| p2_latch | input | 8 | High-port latch value kept for short data cycles and idle |
| ext_access_n | input | 1 | Low selects external code fetches |
| code_lock | input | 1 | Code protection; forces fetches internal |
| ad_in | input | 8 | Byte read from the shared port |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_data | output | 8 | Captured fetch or read byte |
| rsp_ext | output | 1 | Finished cycle used the external bus |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 8 | High address byte port |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |

## Verification
The bound checker watches several relations on every clock. It checks that the three strobes never overlap and that the shared port is released whenever the program-store or read strobe is low. It checks that the write byte is already driven when the write strobe falls and is still driven when it rises. It also checks the two-clock latch pulse, the spacing from the latch fall to the program-store fall, the rise of the latch only after both data strobes are high, the single-clock done pulse, and that no external fetch starts under code protection. Some behaviour only the directed scenarios can show. These are the exact phase of every edge for each cycle kind, the address and data values on both ports, the short-pointer high byte, the captured byte, back-to-back timing, and a mid-cycle request that has no effect.

// File: rtl/xbs_pkg.sv
// Package: shared cycle-kind encoding for the external bus sequencer.
// Assumes the request encoding 00 fetch, 01 read, 10 write; 11 folds to fetch.
package xbs_pkg;

    typedef enum logic [1:0] {
        XK_FETCH = 2'b00,
        XK_READ  = 2'b01,
        XK_WRITE = 2'b10,
        XK_RSVD  = 2'b11
    } xbus_kind_e;

endpackage

// File: rtl/xbs_cycle_ctr.sv
// Module: xbs_cycle_ctr
// Counts oscillator clocks within one machine cycle and decides when a new
// request is taken. Assumes a request is only accepted when idle or in the
// last phase; the counter restarts at phase 0 on acceptance.
module xbs_cycle_ctr #(
    parameter int CYC_LEN = 12,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            accept,
    output logic            active,
    output logic            last,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] PH_END = PH_W'(CYC_LEN - 1);

    // Last phase of a running machine cycle.
    assign last   = active && (phase == PH_END);
    // Take a request when the bus is free or the current cycle ends now.
    assign accept = req_valid && (!active || last);

    // Advance the phase counter and track whether a cycle is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= '0;
        end else if (accept) begin
            active <= 1'b1;
            phase  <= '0;
        end else if (last) begin
            active <= 1'b0;
            phase  <= '0;
        end else if (active) begin
            phase  <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/xbs_req_hold.sv
// Module: xbs_req_hold
// Holds the accepted request for the whole machine cycle and decides whether
// the cycle uses the external bus. Assumes code_lock overrides ext_access_n.
module xbs_req_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [1:0]         req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               req_short,
    input  logic               ext_access_n,
    input  logic               code_lock,
    output xbs_pkg::xbus_kind_e kind_q,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [DATA_W-1:0]  wdata_q,
    output logic               short_q,
    output logic               ext_q
);
    import xbs_pkg::*;

    xbus_kind_e kind_n;
    logic       ext_n;

    // Fold the reserved code onto fetch.
    always_comb begin
        case (req_kind)
            2'b01:   kind_n = XK_READ;
            2'b10:   kind_n = XK_WRITE;
            default: kind_n = XK_FETCH;
        endcase
    end

    // Data cycles are always external; fetches only when allowed and unlocked.
    assign ext_n = (kind_n != XK_FETCH) || (!ext_access_n && !code_lock);

    // Capture the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= XK_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            short_q <= 1'b0;
            ext_q   <= 1'b0;
        end else if (accept) begin
            kind_q  <= kind_n;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            short_q <= req_short;
            ext_q   <= ext_n;
        end
    end

endmodule

// File: rtl/xbs_strobes.sv
// Module: xbs_strobes
// Decodes the phase counter into the latch pulse, the three active-low
// strobes and the shared-port drive windows. Assumes phase positions given as
// absolute phase numbers within the machine cycle, all below CYC_LEN.
module xbs_strobes #(
    parameter int CYC_LEN   = 12,
    parameter int ALE_LAST  = 1,
    parameter int ADR_LAST  = 2,
    parameter int PSN_FIRST = 3,
    parameter int PSN_LAST  = 5,
    parameter int STB_FIRST = 5,
    parameter int STB_LAST  = 10,
    parameter int WD_FIRST  = 4,
    parameter int WD_LAST   = 11,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic                active,
    input  logic [PH_W-1:0]     phase,
    input  xbs_pkg::xbus_kind_e kind,
    input  logic                ext,
    output logic                ale,
    output logic                psen_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic                ad_oe,
    output logic                drive_wdata
);
    import xbs_pkg::*;

    localparam logic [PH_W-1:0] L_ALE  = PH_W'(ALE_LAST);
    localparam logic [PH_W-1:0] L_ADR  = PH_W'(ADR_LAST);
    localparam logic [PH_W-1:0] L_PS0  = PH_W'(PSN_FIRST);
    localparam logic [PH_W-1:0] L_PS1  = PH_W'(PSN_LAST);
    localparam logic [PH_W-1:0] L_ST0  = PH_W'(STB_FIRST);
    localparam logic [PH_W-1:0] L_ST1  = PH_W'(STB_LAST);
    localparam logic [PH_W-1:0] L_WD0  = PH_W'(WD_FIRST);
    localparam logic [PH_W-1:0] L_WD1  = PH_W'(WD_LAST);

    logic bus, in_adr, in_psn, in_stb, in_wd;

    // Phase windows, inclusive at both ends.
    assign bus    = active && ext;
    assign in_adr = (phase <= L_ADR);
    assign in_psn = (phase >= L_PS0) && (phase <= L_PS1);
    assign in_stb = (phase >= L_ST0) && (phase <= L_ST1);
    assign in_wd  = (phase >= L_WD0) && (phase <= L_WD1);

    // Pin-side strobes for the running cycle kind.
    always_comb begin
        ale         = bus && (phase <= L_ALE);
        psen_n      = !(bus && (kind == XK_FETCH) && in_psn);
        rd_n        = !(bus && (kind == XK_READ)  && in_stb);
        wr_n        = !(bus && (kind == XK_WRITE) && in_stb);
        drive_wdata = bus && (kind == XK_WRITE) && in_wd && !in_adr;
        ad_oe       = (bus && in_adr) || drive_wdata;
    end

endmodule

// File: rtl/xbs_port.sv
// Module: xbs_port
// Drives the high-address port and the shared low-address/data port, and
// captures the incoming byte at the fixed sample phase of each read kind.
// Assumes the shared port's output enable is produced by xbs_strobes.
module xbs_port #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int CYC_LEN   = 12,
    parameter int FETCH_SMP = 5,
    parameter int READ_SMP  = 10,
    localparam int PH_W = $clog2(CYC_LEN),
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic [PH_W-1:0]     phase,
    input  xbs_pkg::xbus_kind_e kind,
    input  logic                ext,
    input  logic                short_ptr,
    input  logic                drive_wdata,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [HI_W-1:0]     p2_latch,
    input  logic [DATA_W-1:0]   ad_in,
    output logic [HI_W-1:0]     addr_hi,
    output logic [DATA_W-1:0]   ad_out,
    output logic [DATA_W-1:0]   rsp_data
);
    import xbs_pkg::*;

    localparam logic [PH_W-1:0] L_FS = PH_W'(FETCH_SMP);
    localparam logic [PH_W-1:0] L_RS = PH_W'(READ_SMP);

    logic bus, use_latch, sample;

    assign bus       = active && ext;
    // Short data pointers keep the high port's own latch.
    assign use_latch = !bus || (short_ptr && (kind != XK_FETCH));
    assign addr_hi   = use_latch ? p2_latch : addr[ADDR_W-1:DATA_W];
    // Shared port: address first, write byte later.
    assign ad_out    = drive_wdata ? wdata : addr[DATA_W-1:0];
    // Sample point is the last clock of the relevant strobe.
    assign sample    = bus && (((kind == XK_FETCH) && (phase == L_FS)) ||
                               ((kind == XK_READ)  && (phase == L_RS)));

    // Capture the incoming byte at its sample phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
        end else if (sample) begin
            rsp_data <= ad_in;
        end
    end

endmodule

// File: rtl/xbus_sequencer.sv
// Module: xbus_sequencer
// Top of the multiplexed external bus sequencer. One request runs one machine
// cycle of CYC_LEN oscillator clocks; all strobe edges sit at phases derived
// from the timing parameters below. Assumes the core presents a request only
// when idle or while rsp_done is high.
module xbus_sequencer #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int CYC_LEN   = 12,
    parameter int ALE_W     = 2,
    parameter int ADDR_HOLD = 1,
    parameter int PSEN_GAP  = 1,
    parameter int PSEN_W    = 3,
    parameter int STB_GAP   = 3,
    parameter int STB_W     = 6,
    parameter int WD_LEAD   = 1,
    parameter int WD_TAIL   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_short,
    input  logic [ADDR_W-DATA_W-1:0] p2_latch,
    input  logic                     ext_access_n,
    input  logic                     code_lock,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     rsp_ext,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe
);

    localparam int PH_W      = $clog2(CYC_LEN);
    localparam int ALE_LAST  = ALE_W - 1;
    localparam int ADR_LAST  = ALE_W - 1 + ADDR_HOLD;
    localparam int PSN_FIRST = ALE_W + PSEN_GAP;
    localparam int PSN_LAST  = PSN_FIRST + PSEN_W - 1;
    localparam int STB_FIRST = ALE_W + STB_GAP;
    localparam int STB_LAST  = STB_FIRST + STB_W - 1;
    localparam int WD_FIRST  = STB_FIRST - WD_LEAD;
    localparam int WD_LAST   = STB_LAST + WD_TAIL;

    logic                accept, active, last;
    logic [PH_W-1:0]     phase;
    xbs_pkg::xbus_kind_e kind_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                short_q, ext_q, drive_wdata;

    xbs_cycle_ctr #(.CYC_LEN(CYC_LEN)) u_ctr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .accept(accept), .active(active), .last(last), .phase(phase)
    );

    xbs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_short(req_short), .ext_access_n(ext_access_n),
        .code_lock(code_lock), .kind_q(kind_q), .addr_q(addr_q),
        .wdata_q(wdata_q), .short_q(short_q), .ext_q(ext_q)
    );

    xbs_strobes #(
        .CYC_LEN(CYC_LEN), .ALE_LAST(ALE_LAST), .ADR_LAST(ADR_LAST),
        .PSN_FIRST(PSN_FIRST), .PSN_LAST(PSN_LAST),
        .STB_FIRST(STB_FIRST), .STB_LAST(STB_LAST),
        .WD_FIRST(WD_FIRST), .WD_LAST(WD_LAST)
    ) u_stb (
        .active(active), .phase(phase), .kind(kind_q), .ext(ext_q),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_oe(ad_oe), .drive_wdata(drive_wdata)
    );

    xbs_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_LEN(CYC_LEN),
        .FETCH_SMP(PSN_LAST), .READ_SMP(STB_LAST)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .active(active), .phase(phase),
        .kind(kind_q), .ext(ext_q), .short_ptr(short_q),
        .drive_wdata(drive_wdata), .addr(addr_q), .wdata(wdata_q),
        .p2_latch(p2_latch), .ad_in(ad_in), .addr_hi(addr_hi),
        .ad_out(ad_out), .rsp_data(rsp_data)
    );

    // Response side: done in the last phase, external flag of that cycle.
    assign rsp_done = last;
    assign rsp_ext  = ext_q;

endmodule

// File: rtl/xbs_checker.sv
// Module: xbs_checker
// Cycle-by-cycle properties on the sequencer's pins, bound to the top.
// Assumes the default phase layout (latch 0-1, fetch strobe 3-5, data strobes 5-10).
module xbs_checker (
    input logic clk,
    input logic rst_n,
    input logic ext_access_n,
    input logic code_lock,
    input logic rsp_done,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe
);

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!psen_n, !rd_n, !wr_n}));

    p_ale_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> $past(ale) && $past(ale, 2) && !$past(ale, 3));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_psen_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> !$past(ale) && $past(ale, 2));

    p_psen_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !ad_oe);

    p_rd_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_wdata_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> ad_oe && $past(ad_oe));

    p_wdata_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);

    p_ale_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> rd_n && wr_n && psen_n && $past(rd_n) && $past(wr_n));

    p_lock_internal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> !$past(code_lock, 4) && !$past(ext_access_n, 4));

endmodule

bind xbus_sequencer xbs_checker u_xbs_checker (
    .clk(clk), .rst_n(rst_n), .ext_access_n(ext_access_n),
    .code_lock(code_lock), .rsp_done(rsp_done), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe)
);

// File: tb/tb_xbus_sequencer.sv
// Bench: directed scenarios, one task each, comparing every pin at every
// phase of every machine cycle against values derived from the requirements.
module tb_xbus_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] P2_VAL = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [1:0] req_kind;
    logic [15:0] req_addr;
    logic [7:0] req_wdata;
    logic       req_short;
    logic [7:0] p2_latch;
    logic       ext_access_n;
    logic       code_lock;
    logic [7:0] ad_in;
    logic       rsp_done, rsp_ext, ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0] rsp_data, addr_hi, ad_out;
    logic [7:0] bus_byte;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Simple external memory: returns bus_byte while a read strobe is low.
    assign ad_in = (!psen_n || !rd_n) ? bus_byte : 8'h5A;

    xbus_sequencer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_short(req_short),
        .p2_latch(p2_latch), .ext_access_n(ext_access_n),
        .code_lock(code_lock), .ad_in(ad_in), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .rsp_ext(rsp_ext), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out),
        .ad_oe(ad_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [21:0] pins_now();
        return {ale, psen_n, rd_n, wr_n, ad_oe, rsp_done, addr_hi,
                (ad_oe ? ad_out : 8'h00)};
    endfunction

    task automatic present(input logic [1:0] kind, input logic [15:0] addr,
                           input logic [7:0] wd, input logic sh,
                           input logic ext_n, input logic lock);
        req_kind = kind; req_addr = addr; req_wdata = wd; req_short = sh;
        ext_access_n = ext_n; code_lock = lock; req_valid = 1'b1;
    endtask

    // Follow one machine cycle phase by phase; returns at the negedge of phase 11.
    task automatic watch(input string tag, input logic [1:0] kind,
                         input logic [15:0] addr, input logic [7:0] wd,
                         input logic sh, input logic ext_n, input logic lock,
                         input logic [7:0] byte_in, input bit poke);
        logic fetch, bus;
        logic [7:0] hi_e, lo_e;
        logic e_ale, e_ps, e_rd, e_wr, e_oe;
        fetch = (kind == 2'b00) || (kind == 2'b11);
        bus   = !fetch || (!ext_n && !lock);
        bus_byte = byte_in;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            e_ale = bus && (k <= 1);
            e_ps  = !(bus && fetch && k >= 3 && k <= 5);
            e_rd  = !(bus && kind == 2'b01 && k >= 5 && k <= 10);
            e_wr  = !(bus && kind == 2'b10 && k >= 5 && k <= 10);
            e_oe  = bus && ((k <= 2) || (kind == 2'b10 && k >= 4));
            lo_e  = !e_oe ? 8'h00 : (k <= 2 ? addr[7:0] : wd);
            hi_e  = (bus && !(sh && !fetch)) ? addr[15:8] : P2_VAL;
            check(tag, $sformatf("pins phase %0d", k), 32'(pins_now()),
                  32'({e_ale, e_ps, e_rd, e_wr, e_oe, (k == 11), hi_e, lo_e}));
            if (k == 11) begin
                check(tag, "rsp_ext", 32'(rsp_ext), 32'(bus));
                if (bus && kind != 2'b10)
                    check(tag, "returned byte", 32'(rsp_data), 32'(byte_in));
            end
            if (poke && k == 4) present(2'b10, 16'h0BAD, 8'hEE, 1'b0, ext_n, lock);
            if (poke && k == 5) req_valid = 1'b0;
        end
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        check(tag, "idle pins", 32'(pins_now()),
              32'({1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, P2_VAL, 8'h00}));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
        req_wdata = '0; req_short = 1'b0; p2_latch = P2_VAL;
        ext_access_n = 1'b0; code_lock = 1'b0; bus_byte = 8'h00;
        repeat (3) @(negedge clk);
        check("R1", "reset pins", 32'(pins_now()),
              32'({1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, P2_VAL, 8'h00}));
        rst_n = 1'b1;
        idle_check("R1");
    endtask

    task automatic t_fetch();
        // R2 R3 R4: external fetch, then idle
        present(2'b00, 16'h12A7, 8'h00, 1'b0, 1'b0, 1'b0);
        watch("R4", 2'b00, 16'h12A7, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0);
        idle_check("R2");
        // reserved code 11 behaves as a fetch
        present(2'b11, 16'h0F10, 8'h00, 1'b1, 1'b0, 1'b0);
        watch("R4", 2'b11, 16'h0F10, 8'h00, 1'b1, 1'b0, 1'b0, 8'h81, 1'b0);
        idle_check("R3");
    endtask

    task automatic t_read_write();
        present(2'b01, 16'hBEEF, 8'h00, 1'b0, 1'b0, 1'b0);
        watch("R5/R8", 2'b01, 16'hBEEF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h96, 1'b0);
        idle_check("R5");
        present(2'b10, 16'h4321, 8'hA5, 1'b0, 1'b1, 1'b1);
        watch("R6", 2'b10, 16'h4321, 8'hA5, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
        idle_check("R6");
    endtask

    task automatic t_short_ptr();
        present(2'b01, 16'h7755, 8'h00, 1'b1, 1'b0, 1'b0);
        watch("R7", 2'b01, 16'h7755, 8'h00, 1'b1, 1'b0, 1'b0, 8'h42, 1'b0);
        present(2'b10, 16'h6633, 8'h19, 1'b1, 1'b0, 1'b0);
        watch("R7", 2'b10, 16'h6633, 8'h19, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        idle_check("R7");
    endtask

    task automatic t_internal();
        present(2'b00, 16'h2468, 8'h00, 1'b0, 1'b1, 1'b0);
        watch("R10", 2'b00, 16'h2468, 8'h00, 1'b0, 1'b1, 1'b0, 8'h11, 1'b0);
        present(2'b00, 16'h1357, 8'h00, 1'b0, 1'b0, 1'b1);
        watch("R10", 2'b00, 16'h1357, 8'h00, 1'b0, 1'b0, 1'b1, 8'h22, 1'b0);
        idle_check("R10");
    endtask

    task automatic t_back_to_back();
        // R9: each next request is given during the done clock
        present(2'b01, 16'hA001, 8'h00, 1'b0, 1'b0, 1'b0);
        watch("R9", 2'b01, 16'hA001, 8'h00, 1'b0, 1'b0, 1'b0, 8'h5C, 1'b0);
        present(2'b10, 16'hA002, 8'h7E, 1'b0, 1'b0, 1'b0);
        watch("R9", 2'b10, 16'hA002, 8'h7E, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        present(2'b00, 16'hA003, 8'h00, 1'b0, 1'b0, 1'b0);
        watch("R9", 2'b00, 16'hA003, 8'h00, 1'b0, 1'b0, 1'b0, 8'hD4, 1'b0);
        idle_check("R9");
    endtask

    task automatic t_ignore_midcycle();
        present(2'b01, 16'h3C3C, 8'h00, 1'b0, 1'b0, 1'b0);
        watch("R11", 2'b01, 16'h3C3C, 8'h00, 1'b0, 1'b0, 1'b0, 8'hE7, 1'b1);
        idle_check("R11");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fetch();
        t_read_write();
        t_short_ptr();
        t_internal();
        t_back_to_back();
        t_ignore_midcycle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule